// File: doc/BRIEF.md
# SPI register-access command decoder

This block is an SPI slave that fronts a small bank of 8-bit configuration registers. The master drives the serial clock and the serial input and holds an active-low select. The block samples the serial input on rising clock edges and changes its serial output after falling edges, which is mode-0 timing. All serial inputs are resynchronised into the system clock domain and edge-detected there. The system clock must run at least four times faster than the serial clock.

Each transfer begins with a command byte. A burst command is two header bytes. The first header byte names the direction and a 5-bit start address. The second header byte gives the burst length minus one. A read burst then shifts out consecutive registers, most significant bit first. A write burst accepts consecutive data bytes and stores each one. The address advances by one after every data byte. Two single-byte opcodes turn a streaming flag on and off. While the flag is set, burst commands are locked out. After a command finishes, the next byte in the same frame is decoded as a new command. Raising the select aborts whatever command is in progress.

Top module: `spi_reg_port`

## Requirements
- R1: A first header byte of binary form 001a_aaaa, followed by a count byte whose low five bits hold n, reads n+1 registers. The read starts at address a_aaaa. Each register is sent MSB first. The MSB of the first register is valid on dout for the master to sample at the 17th rising sclk edge of the frame.
- R2: A first header byte of binary form 010a_aaaa, followed by a count byte holding n in its low five bits, is followed by n+1 data bytes. The data bytes arrive MSB first and are stored at consecutive addresses, starting at a_aaaa.
- R3: The address rises by one after each data byte. An address at or above NUM_REGS (default 12) reads as 0x00 and discards writes. This holds even when the address passes 31.
- R4: Address 0 always reads ID_VALUE (default 0xA5). Writes to address 0 are discarded.
- R5: The single-byte opcode 0x10 sets stream_active. The single-byte opcode 0x11 clears it. The flag keeps its value while cs_n is high.
- R6: While stream_active is 1, a read or write command is ignored for the rest of its frame. During that time dout stays 0 and no register changes.
- R7: Raising cs_n aborts the current command, including a partly received byte. The next frame then decodes its first eight bits as a fresh command byte.
- R8: dout is 0 whenever the block is not in a read data phase. This covers header bytes, bytes after a finished burst, and cs_n high.
- R9: After a command completes, the next byte in the same frame is decoded as a new command. A byte that is neither a burst header nor 0x10 or 0x11 is ignored.
- R10: After reset, every register except address 0 reads 0x00, stream_active is 0 and dout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Active-low select; high aborts the frame |
| din | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data to the master, 0 outside read data |
| stream_active | output | 1 | Streaming flag that locks out burst commands |

## Verification
A table of write-then-read bursts covers several shapes:
- a single byte;
- a four-byte burst;
- a burst that starts on the identification register;
- a burst that runs past the last implemented register;
- a burst that starts at address 31, so every byte falls outside the bank.

Comparing each read-back byte with a bench model separates three effects: the address auto-increment, the read-only identification register, and the out-of-range discard. The model also checks that each burst stops after count plus one bytes.

Directed frames then cover the remaining behaviour:
- Streaming lockout: they issue bursts while streaming is on and confirm that nothing was read or written.
- Mid-byte abort: they raise select partway through a data byte and check that the register is untouched.
- Chained commands: they send several commands in one frame, including an unknown opcode, and watch that dout is quiet around the read data.

// File: rtl/spi_reg_pkg.sv
// Package: shared types and command encodings for the SPI register port.
// Assumes the header carries a 5-bit address field and a 5-bit count field.
package spi_reg_pkg;

    // Width of the address and count fields in the header bytes.
    localparam int HDR_ADDR_W = 5;

    // Top three bits of the first header byte select the burst direction.
    localparam logic [2:0] GRP_READ  = 3'b001;
    localparam logic [2:0] GRP_WRITE = 3'b010;

    // Single-byte opcodes that drive the streaming flag.
    localparam logic [7:0] OP_STREAM_ON  = 8'h10;
    localparam logic [7:0] OP_STREAM_OFF = 8'h11;

    // Decoder phase within a frame.
    typedef enum logic [2:0] {
        PH_OPCODE = 3'd0,
        PH_COUNT  = 3'd1,
        PH_READ   = 3'd2,
        PH_WRITE  = 3'd3,
        PH_IGNORE = 3'd4
    } phase_t;

endpackage

// File: rtl/spi_reg_sync.sv
// Module: spi_reg_sync
// Brings sclk, cs_n and din into the clk domain through STAGES flops.
// Produces one-cycle rising and falling strobes for sclk, gated by select.
// Assumes clk runs at least four times sclk, so no edge is missed.
module spi_reg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_idle,
    output logic din_s
);

    localparam int LANES = 3;
    localparam logic [LANES-1:0] IDLE_VAL = 3'b100;   // {cs_n, sclk, din}

    logic [LANES-1:0] stage_q [STAGES];
    logic             sclk_d;
    logic [LANES-1:0] synced;

    for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
        if (gs == 0) begin : g_first
            // First flop of the chain: captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gs] <= IDLE_VAL;
                else        stage_q[gs] <= {cs_n, sclk, din};
            end
        end else begin : g_next
            // Later flops: pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gs] <= IDLE_VAL;
                else        stage_q[gs] <= stage_q[gs-1];
            end
        end
    end

    assign synced = stage_q[STAGES-1];

    // Delayed copy of the synced sclk, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= synced[1];
    end

    // Edge strobes are suppressed while the select is inactive.
    always_comb begin
        cs_idle   = synced[2];
        din_s     = synced[0];
        sclk_rise = synced[1] & ~sclk_d & ~synced[2];
        sclk_fall = ~synced[1] & sclk_d & ~synced[2];
    end

endmodule

// File: rtl/spi_reg_bank.sv
// Module: spi_reg_bank
// Bank of NUM_REGS 8-bit registers. Entry 0 is a fixed identification value.
// Writes and reads at addresses >= NUM_REGS are discarded and return zero.
// Assumes one write per cycle at most; the read port is combinational.
module spi_reg_bank #(
    parameter int         NUM_REGS = 12,
    parameter logic [7:0] ID_VALUE = 8'hA5,
    parameter int         AW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] reg_vec [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        if (gi == 0) begin : g_id
            assign reg_vec[gi] = ID_VALUE;
        end else begin : g_rw
            logic [7:0] value_q;
            // Holds one configuration byte; loads on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)                              value_q <= 8'h00;
                else if (wr_en && wr_addr == AW'(gi))    value_q <= wr_data;
            end
            assign reg_vec[gi] = value_q;
        end
    end

    // Read multiplexer; out-of-range addresses match nothing and give zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == AW'(i)) rd_data = reg_vec[i];
        end
    end

endmodule

// File: rtl/spi_reg_ctrl.sv
// Module: spi_reg_ctrl
// Command decoder: shifts in bytes, decodes the two-byte burst header,
// auto-increments the address and sequences read and write bursts.
// Also owns the streaming flag. Works on the edge strobes from spi_reg_sync.
// Assumes rd_data settles in the same cycle as rd_addr.
module spi_reg_ctrl
    import spi_reg_pkg::*;
#(
    parameter int AW = HDR_ADDR_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs_idle,
    input  logic          din_s,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          dout,
    output logic          stream_active
);

    localparam int CW = HDR_ADDR_W;

    phase_t          phase_q, phase_n;
    logic [2:0]      bit_q, bit_n;
    logic [7:0]      rx_q, rx_n, rx_next;
    logic [7:0]      tx_q, tx_n;
    logic [AW-1:0]   addr_q, addr_n;
    logic [CW-1:0]   remain_q, remain_n;
    logic            rd_mode_q, rd_mode_n;
    logic            stream_q, stream_n;
    logic            byte_done;
    logic            is_burst;

    // Next-state logic for the whole decoder.
    always_comb begin
        rx_next   = {rx_q[6:0], din_s};
        byte_done = sclk_rise && (bit_q == 3'd7);
        is_burst  = (rx_next[7:5] == GRP_READ) || (rx_next[7:5] == GRP_WRITE);

        phase_n   = phase_q;
        bit_n     = bit_q;
        rx_n      = rx_q;
        tx_n      = tx_q;
        addr_n    = addr_q;
        remain_n  = remain_q;
        rd_mode_n = rd_mode_q;
        stream_n  = stream_q;
        wr_en     = 1'b0;

        if (cs_idle) begin
            phase_n = PH_OPCODE;
            bit_n   = 3'd0;
            tx_n    = 8'h00;
        end else begin
            if (sclk_rise) begin
                rx_n  = rx_next;
                bit_n = bit_q + 3'd1;
            end
            if (byte_done) begin
                unique case (phase_q)
                    PH_OPCODE: begin
                        if (is_burst) begin
                            if (stream_q) begin
                                phase_n = PH_IGNORE;
                            end else begin
                                addr_n    = {1'b0, rx_next[CW-1:0]};
                                rd_mode_n = (rx_next[7:5] == GRP_READ);
                                phase_n   = PH_COUNT;
                            end
                        end else if (rx_next == OP_STREAM_ON) begin
                            stream_n = 1'b1;
                        end else if (rx_next == OP_STREAM_OFF) begin
                            stream_n = 1'b0;
                        end
                    end
                    PH_COUNT: begin
                        remain_n = rx_next[CW-1:0];
                        tx_n     = 8'h00;
                        phase_n  = rd_mode_q ? PH_READ : PH_WRITE;
                    end
                    PH_READ: begin
                        addr_n = addr_q + AW'(1);
                        if (remain_q == '0) phase_n = PH_OPCODE;
                        else                remain_n = remain_q - CW'(1);
                    end
                    PH_WRITE: begin
                        wr_en  = 1'b1;
                        addr_n = addr_q + AW'(1);
                        if (remain_q == '0) phase_n = PH_OPCODE;
                        else                remain_n = remain_q - CW'(1);
                    end
                    default: ;
                endcase
            end
            if (sclk_fall && phase_q == PH_READ) begin
                tx_n = (bit_q == 3'd0) ? rd_data : {tx_q[6:0], 1'b0};
            end
        end
    end

    // State registers of the decoder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_OPCODE;
            bit_q     <= 3'd0;
            rx_q      <= 8'h00;
            tx_q      <= 8'h00;
            addr_q    <= '0;
            remain_q  <= '0;
            rd_mode_q <= 1'b0;
            stream_q  <= 1'b0;
        end else begin
            phase_q   <= phase_n;
            bit_q     <= bit_n;
            rx_q      <= rx_n;
            tx_q      <= tx_n;
            addr_q    <= addr_n;
            remain_q  <= remain_n;
            rd_mode_q <= rd_mode_n;
            stream_q  <= stream_n;
        end
    end

    // Output drive: dout is live only during the read data phase.
    always_comb begin
        rd_addr       = addr_q;
        wr_addr       = addr_q;
        wr_data       = rx_next;
        dout          = (phase_q == PH_READ) & tx_q[7];
        stream_active = stream_q;
    end

endmodule

// File: rtl/spi_reg_port.sv
// Module: spi_reg_port (top)
// SPI slave giving burst read and write access to a small register bank.
// The serial clock is in mode-0 timing and the select is active low.
// Assumes clk is at least four times sclk and that NUM_REGS <= 32.
module spi_reg_port #(
    parameter int         NUM_REGS    = 12,
    parameter logic [7:0] ID_VALUE    = 8'hA5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic dout,
    output logic stream_active
);

    localparam int AW = spi_reg_pkg::HDR_ADDR_W + 1;

    logic          sclk_rise;
    logic          sclk_fall;
    logic          cs_idle;
    logic          din_s;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    spi_reg_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .din       (din),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_idle   (cs_idle),
        .din_s     (din_s)
    );

    spi_reg_ctrl #(
        .AW (AW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_rise     (sclk_rise),
        .sclk_fall     (sclk_fall),
        .cs_idle       (cs_idle),
        .din_s         (din_s),
        .rd_data       (rd_data),
        .rd_addr       (rd_addr),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .dout          (dout),
        .stream_active (stream_active)
    );

    spi_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .ID_VALUE (ID_VALUE),
        .AW       (AW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/spi_reg_port_chk.sv
// Module: spi_reg_port_chk
// Temporal checks on the SPI register port, bound into every instance.
module spi_reg_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic cs_idle,
    input logic wr_en,
    input logic dout,
    input logic stream_active
);

    // R8, R7: one cycle after the select is seen high, dout is quiet.
    assert_dout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !dout);

    // R5: the streaming flag only moves as a result of a received bit.
    assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(stream_active));

    // R2: a register write is only issued on a serial clock rising edge.
    assert_write_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sclk_rise && !cs_idle));

    // R1: dout only changes in response to an edge or to the select.
    assert_dout_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !sclk_fall && !cs_idle) |=> $stable(dout));

endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk_rise     (sclk_rise),
    .sclk_fall     (sclk_fall),
    .cs_idle       (cs_idle),
    .wr_en         (wr_en),
    .dout          (dout),
    .stream_active (stream_active)
);

// File: tb/spi_reg_port_bench.sv
// Bench for spi_reg_port: a vector table of bursts, then directed frames.
module spi_reg_port_bench;

    localparam int         NUM_REGS = 12;
    localparam logic [7:0] ID_VALUE = 8'hA5;
    localparam int         HALF     = 8;      // clk cycles per sclk half period

    typedef struct packed {
        logic [4:0] addr;
        logic [4:0] nm1;
        logic [7:0] seed;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{addr: 5'd1,  nm1: 5'd0, seed: 8'h3C},
        '{addr: 5'd2,  nm1: 5'd3, seed: 8'h50},
        '{addr: 5'd0,  nm1: 5'd2, seed: 8'h77},
        '{addr: 5'd10, nm1: 5'd3, seed: 8'h90},
        '{addr: 5'd6,  nm1: 5'd4, seed: 8'hC1},
        '{addr: 5'd31, nm1: 5'd1, seed: 8'hEE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic dout;
    logic stream_active;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic [7:0] model [64];

    always #5 clk = ~clk;

    spi_reg_port #(
        .NUM_REGS (NUM_REGS),
        .ID_VALUE (ID_VALUE)
    ) u_spi_reg_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk          (sclk),
        .cs_n          (cs_n),
        .din           (din),
        .dout          (dout),
        .stream_active (stream_active)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input int a);
        return (a < NUM_REGS) ? model[a] : 8'h00;
    endfunction

    task automatic model_wr(input int a, input logic [7:0] d);
        if (a != 0 && a < NUM_REGS) model[a] = d;
    endtask

    // Sends nbits of a byte MSB first and samples dout before each rise.
    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            din = tx[i];
            waitc(HALF);
            rx[i] = dout;
            sclk = 1'b1;
            waitc(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic cs_low;
        cs_n = 1'b0;
        waitc(HALF);
    endtask

    task automatic cs_high;
        waitc(HALF);
        cs_n = 1'b1;
        din  = 1'b0;
        waitc(4 * HALF);
    endtask

    // Reads one register in its own frame and compares it with the model.
    task automatic read_one(input int a, input string tag);
        logic [7:0] rx;
        cs_low;
        xfer(8'h20 | 8'(a), rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        chk(tag, rx, model_rd(a));
        cs_high;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic [7:0] d;
        string      tag;
        int         a;

        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        model[0] = ID_VALUE;

        // R10: reset state at the ports.
        waitc(6);
        chk("R10 dout", {7'b0, dout}, 8'h00);
        chk("R10 stream", {7'b0, stream_active}, 8'h00);
        rst_n = 1'b1;
        waitc(4);

        // R10, R4, R3: one burst over the whole bank and two bytes beyond it.
        cs_low;
        xfer(8'h20, rx);
        chk("R8 header", rx, 8'h00);
        xfer(8'(NUM_REGS + 1), rx);
        chk("R8 count", rx, 8'h00);
        for (int k = 0; k < NUM_REGS + 2; k++) begin
            xfer(8'h00, rx);
            tag = (k == 0) ? "R4 id" : ((k >= NUM_REGS) ? "R3 beyond" : "R10 clear");
            chk(tag, rx, model_rd(k));
        end
        cs_high;

        // Vector table: write burst, then read the same span back.
        for (int v = 0; v < NVEC; v++) begin
            cs_low;
            xfer(8'h40 | 8'(VEC[v].addr), rx);
            xfer(8'(VEC[v].nm1), rx);
            for (int k = 0; k <= int'(VEC[v].nm1); k++) begin
                d = VEC[v].seed + 8'(k * 17);
                xfer(d, rx);
                model_wr(int'(VEC[v].addr) + k, d);
            end
            cs_high;

            cs_low;
            xfer(8'h20 | 8'(VEC[v].addr), rx);
            xfer(8'(VEC[v].nm1), rx);
            for (int k = 0; k <= int'(VEC[v].nm1); k++) begin
                a = int'(VEC[v].addr) + k;
                xfer(8'h00, rx);
                tag = (a == 0) ? "R4 burst" : ((a >= NUM_REGS) ? "R3 burst" : "R2 R1 burst");
                chk(tag, rx, model_rd(a));
            end
            // R8: one byte after the burst, decoded as a no-op.
            xfer(8'h00, rx);
            chk("R8 after burst", rx, 8'h00);
            cs_high;
            chk("R8 cs high", {7'b0, dout}, 8'h00);
        end

        // R5, R6: streaming lockout of reads and writes.
        cs_low;
        xfer(8'h10, rx);
        cs_high;
        chk("R5 stream on", {7'b0, stream_active}, 8'h01);
        cs_low;
        xfer(8'h21, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        chk("R6 read locked", rx, 8'h00);
        cs_high;
        cs_low;
        xfer(8'h43, rx);
        xfer(8'h00, rx);
        xfer(8'hFF, rx);
        cs_high;
        chk("R5 stream kept", {7'b0, stream_active}, 8'h01);
        cs_low;
        xfer(8'h11, rx);
        cs_high;
        chk("R5 stream off", {7'b0, stream_active}, 8'h00);
        read_one(3, "R6 write locked");
        read_one(1, "R6 reg1 intact");

        // R7: abort in the middle of a data byte, then a fresh frame.
        cs_low;
        xfer(8'h44, rx);
        xfer(8'h00, rx);
        xfer_bits(8'h0F, 4, rx);
        cs_high;
        read_one(4, "R7 abort");
        cs_low;
        xfer_bits(8'h45, 3, rx);
        cs_high;
        cs_low;
        xfer(8'h47, rx);
        xfer(8'h00, rx);
        xfer(8'h5A, rx);
        model_wr(7, 8'h5A);
        cs_high;
        read_one(7, "R7 fresh frame");

        // R9: chained commands with an unknown opcode in one frame.
        cs_low;
        xfer(8'h48, rx);
        xfer(8'h00, rx);
        xfer(8'hB3, rx);
        model_wr(8, 8'hB3);
        xfer(8'h7E, rx);
        chk("R9 unknown quiet", rx, 8'h00);
        xfer(8'h28, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        chk("R9 chained read", rx, 8'hB3);
        xfer(8'h00, rx);
        chk("R8 chained tail", rx, 8'h00);
        xfer(8'h10, rx);
        waitc(2 * HALF);
        chk("R9 chained stream", {7'b0, stream_active}, 8'h01);
        xfer(8'h11, rx);
        cs_high;
        chk("R9 chained off", {7'b0, stream_active}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule